// File: doc/BRIEF.md
# Repeating Time-of-Day Alarm

This block holds four alarm bytes (seconds, minutes, hours and day of month) and compares them against a running BCD time of day supplied from outside. The comparison is made once for each one-cycle seconds strobe, and a matching second produces a single-cycle interrupt pulse. The top bit of each alarm byte is a repeat-mask flag. The pattern of set flags selects how often the alarm repeats: monthly, daily, hourly, every minute or every second.

Software reaches the four bytes through a small byte-wide port. A write that carries an out-of-range BCD value is dropped, so the stored byte keeps its earlier value. A read returns the stored byte as written, mask flag included. Timekeeping and bus address decoding belong to neighbouring blocks. This block only validates, stores, compares and pulses.

Top module: `tod_alarm`

## Requirements
- R1: The register select `reg_sel` picks 0 = seconds, 1 = minutes, 2 = hours, 3 = date. `rd_data` shows the stored byte of the selected register in the same cycle, all eight bits including the mask flag in bit 7.
- R2: A write to seconds or minutes is stored (all 8 bits) only if bits[6:4]*10 + bits[3:0] is at most 59. Otherwise the register is unchanged.
- R3: A write to hours is stored (all 8 bits) only if bits[5:4]*10 + bits[3:0] is at most 23. Otherwise the register is unchanged.
- R4: A write to date is stored (all 8 bits) only if bits[5:4]*10 + bits[3:0] is nonzero. Otherwise the register is unchanged.
- R5: With no mask flag set, a tick fires when all four fields match. Seconds and minutes compare bits[6:0], and hours and date compare bits[5:0].
- R6: With only the date flag set, a tick fires when seconds, minutes and hours match.
- R7: With only the date and hours flags set, a tick fires when seconds and minutes match.
- R8: With the date, hours and minutes flags set and the seconds flag clear, a tick fires when seconds match.
- R9: Any other flag pattern makes every tick fire.
- R10: `alarm_irq` is high for exactly the one cycle after a clock edge that sampled `sec_tick` high with the fire condition true. It is low at all other times.
- R11: A synchronous active-low reset clears all four registers to 0x00 and holds `alarm_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register select for write and read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Stored byte of the selected register |
| sec_tick | input | 1 | One-cycle strobe per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| alarm_irq | output | 1 | Single-cycle alarm pulse |

## Verification
The hardest case to reach is one where a single field differs while the flag pattern makes that field irrelevant. A wrong field-to-flag pairing then shows up only for that one pattern. The stimulus covers all 16 flag patterns, and for each pattern it applies a full match, one mismatch in each field, and a mismatch in every field. The expected pulse is computed from the rate rules. The write filter is swept over all 256 byte values on each register. Each value follows a known valid write, so a dropped write shows up as that earlier value on read-back.

// File: rtl/tod_alarm_pkg.sv
// Shared constants and helpers for the time-of-day alarm.
// Assumes BCD fields of one byte each; nibble digits are not range-checked.
package tod_alarm_pkg;
    localparam int unsigned DW       = 8;
    localparam int unsigned N_FIELDS = 4;
    localparam int unsigned SEL_W    = $clog2(N_FIELDS);
    localparam int unsigned MASK_BIT = DW - 1;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } fld_e;

    // Decimal value of the low seven bits read as two BCD digits.
    function automatic int unsigned bcd7(input logic [DW-1:0] v);
        return int'(v[6:4]) * 10 + int'(v[3:0]);
    endfunction

    // Decimal value of the low six bits read as two BCD digits.
    function automatic int unsigned bcd6(input logic [DW-1:0] v);
        return int'(v[5:4]) * 10 + int'(v[3:0]);
    endfunction

    // Bits of a field that take part in the comparison.
    function automatic logic [DW-1:0] cmp_mask(input int unsigned kind);
        return (kind < 2) ? 8'h7F : 8'h3F;
    endfunction
endpackage

// File: rtl/tod_alarm_fieldreg.sv
// One alarm byte with its write filter.
// KIND selects the range rule: 0/1 seconds/minutes, 2 hours, 3 date.
// Assumes wr_hit is already decoded for this field.
module tod_alarm_fieldreg
    import tod_alarm_pkg::*;
#(
    parameter int unsigned KIND = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] q
);
    logic accept;

    // Range check on the incoming byte for this field kind.
    always_comb begin
        case (KIND)
            0, 1:    accept = (bcd7(wr_data) <= 59);
            2:       accept = (bcd6(wr_data) <= 23);
            default: accept = (bcd6(wr_data) != 0);
        endcase
    end

    // Store the full byte when the write passes the filter.
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= '0;
        else if (wr_hit && accept) q <= wr_data;
    end
endmodule

// File: rtl/tod_alarm_match.sv
// Compares alarm bytes with the current time and decodes the repeat rate
// from the four mask flags. Purely combinational.
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic [DW-1:0] alm [N_FIELDS],
    input  logic [DW-1:0] cur [N_FIELDS],
    output logic          hit
);
    logic [N_FIELDS-1:0] eq;
    logic [N_FIELDS-1:0] flag;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
        assign eq[i]   = (((alm[i] ^ cur[i]) & cmp_mask(i)) == '0);
        assign flag[i] = alm[i][MASK_BIT];
    end

    // Pick the fields that must agree from the flag pattern (date..sec).
    always_comb begin
        case (flag)
            4'b0000: hit = &eq;
            4'b1000: hit = eq[FLD_SEC] & eq[FLD_MIN] & eq[FLD_HOUR];
            4'b1100: hit = eq[FLD_SEC] & eq[FLD_MIN];
            4'b1110: hit = eq[FLD_SEC];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/tod_alarm.sv
// Time-of-day alarm: four filtered alarm bytes, a repeat-rate match and a
// registered one-cycle interrupt. Assumes sec_tick is a single-cycle strobe
// and that the time inputs are stable around it.
module tod_alarm
    import tod_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             sec_tick,
    input  logic [DW-1:0]    cur_sec,
    input  logic [DW-1:0]    cur_min,
    input  logic [DW-1:0]    cur_hour,
    input  logic [DW-1:0]    cur_date,
    output logic             alarm_irq
);
    logic [DW-1:0] fld_q [N_FIELDS];
    logic [DW-1:0] cur_v [N_FIELDS];
    logic          hit;

    assign cur_v[FLD_SEC]  = cur_sec;
    assign cur_v[FLD_MIN]  = cur_min;
    assign cur_v[FLD_HOUR] = cur_hour;
    assign cur_v[FLD_DATE] = cur_date;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
        tod_alarm_fieldreg #(.KIND(i)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_en && (reg_sel == SEL_W'(i))),
            .wr_data (wr_data),
            .q       (fld_q[i])
        );
    end

    tod_alarm_match u_match (
        .alm (fld_q),
        .cur (cur_v),
        .hit (hit)
    );

    // Read mux over the stored bytes.
    assign rd_data = fld_q[reg_sel];

    // One pulse per qualifying tick.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_irq <= 1'b0;
        else        alarm_irq <= sec_tick && hit;
    end
endmodule

// File: rtl/tod_alarm_chk.sv
// Temporal checks on the alarm block, attached by bind.
module tod_alarm_chk
    import tod_alarm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] reg_sel,
    input logic [DW-1:0]    wr_data,
    input logic             sec_tick,
    input logic             alarm_irq,
    input logic [DW-1:0]    r_sec,
    input logic [DW-1:0]    r_min,
    input logic [DW-1:0]    r_hour,
    input logic [DW-1:0]    r_date
);
    // R2
    sec_bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0 && bcd7(wr_data) > 59) |=> $stable(r_sec));
    // R2
    min_good_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1 && bcd7(wr_data) <= 59) |=> (r_min == $past(wr_data)));
    // R3
    hour_bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2 && bcd6(wr_data) > 23) |=> $stable(r_hour));
    // R4
    date_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3 && bcd6(wr_data) == 0) |=> $stable(r_date));
    // R10
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !alarm_irq);
endmodule

bind tod_alarm tod_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .wr_data   (wr_data),
    .sec_tick  (sec_tick),
    .alarm_irq (alarm_irq),
    .r_sec     (fld_q[0]),
    .r_min     (fld_q[1]),
    .r_hour    (fld_q[2]),
    .r_date    (fld_q[3])
);

// File: tb/sim_tod_alarm.sv
module sim_tod_alarm;
    localparam time PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic       alarm_irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    tod_alarm u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = 2'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        reg_sel = 2'(a);
        #1;
        check(req, int'(rd_data), exp);
    endtask

    function automatic bit valid(input int f, input int v);
        int hi7 = (v >> 4) & 7;
        int hi6 = (v >> 4) & 3;
        int lo  = v & 15;
        if (f < 2)  return (hi7 * 10 + lo) <= 59;
        if (f == 2) return (hi6 * 10 + lo) <= 23;
        return (hi6 * 10 + lo) != 0;
    endfunction

    function automatic string vreq(input int f);
        if (f < 2)  return "R2";
        if (f == 2) return "R3";
        return "R4";
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base [4] = '{8'h37, 8'h42, 8'h55, 8'h28};
        int diff [4] = '{8'h38, 8'h43, 8'h16, 8'h29};
        repeat (3) @(negedge clk);
        // R11: reset state
        for (int f = 0; f < 4; f++) rd_check("R11 reset reg", f, 0);
        check("R11 reset irq", int'(alarm_irq), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: full byte sweep per register
        for (int f = 0; f < 4; f++) begin
            for (int v = 0; v < 256; v++) begin
                wr(f, 8'h01);
                wr(f, 8'(v));
                rd_check(valid(f, v) ? "R1 stored byte" : vreq(f), f,
                         valid(f, v) ? v : 8'h01);
            end
        end

        // R5..R10: every flag pattern against several time vectors
        for (int mk = 0; mk < 16; mk++) begin
            for (int f = 0; f < 4; f++)
                wr(f, 8'(base[f] | (((mk >> f) & 1) << 7)));
            for (int vec = 0; vec < 6; vec++) begin
                int eqv [4];
                bit exp;
                string req;
                for (int f = 0; f < 4; f++) begin
                    eqv[f] = !((vec == f + 1) || (vec == 5));
                end
                @(negedge clk);
                cur_sec  = 8'((eqv[0] != 0) ? base[0] : diff[0]);
                cur_min  = 8'((eqv[1] != 0) ? base[1] : diff[1]);
                cur_hour = 8'((eqv[2] != 0) ? 8'h15 : diff[2]);
                cur_date = 8'((eqv[3] != 0) ? base[3] : diff[3]);
                case (mk)
                    0:  begin exp = (eqv[0] & eqv[1] & eqv[2] & eqv[3]) != 0; req = "R5"; end
                    8:  begin exp = (eqv[0] & eqv[1] & eqv[2]) != 0; req = "R6"; end
                    12: begin exp = (eqv[0] & eqv[1]) != 0; req = "R7"; end
                    14: begin exp = eqv[0] != 0; req = "R8"; end
                    default: begin exp = 1'b1; req = "R9"; end
                endcase
                @(negedge clk);
                check("R10 no tick no pulse", int'(alarm_irq), 0);
                sec_tick = 1'b1;
                @(negedge clk);
                sec_tick = 1'b0;
                check(req, int'(alarm_irq), int'(exp));
                @(negedge clk);
                check("R10 pulse width", int'(alarm_irq), 0);
            end
        end

        // R11: reset in mid-run clears stored bytes
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int f = 0; f < 4; f++) rd_check("R11 mid-run reset", f, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule